// File: doc/BRIEF.md
# Shared-Field Configuration Register Bank with Access Locks

This block is a small memory-mapped configuration bank on a plain strobe bus. It takes an address, write data, a write strobe and a read strobe, and it returns 32-bit read data in the same cycle. It holds three one-bit fields, and each field also drives a hardware-side output.

One of those fields, the shared bit, has no fixed home. It is one flip-flop that answers at two addresses. The primary address gives unconditional read-write access. The secondary (alias) address gives gated access:
- A write through the alias is dropped while the write-lock condition holds. That condition is the guard bit of the control register, ORed with an external lock input.
- A read through the alias returns zero in the field position while the read-lock condition holds. That condition is the inverse of the control register's open bit.

The bank is used by letting one agent own the primary address while other agents go through the alias. The control register opens or closes the alias.

Top module: `cfg_alias_bank`

## Requirements
- R1: An active-low synchronous reset sets the shared bit, the open bit and the guard bit to 1, so all three hardware outputs read 1. A write presented during reset is ignored.
- R2: A write to the primary address (base + 0x08) always loads write-data bit 0 into the shared bit on the clock edge that samples the strobe. A read there returns the shared bit at bit 0 with every other bit zero.
- R3: A write to the alias address (base + 0x00) while not write-locked loads write-data bit 0 into the same shared bit. The new value is then visible through the primary address and on the hardware output.
- R4: While the write lock is active (control bit 2 is 1, or the external lock input is 1), writes through the alias address leave the shared bit unchanged. Writes through the primary address still take effect.
- R5: While control bit 0 is 0, a read through the alias address returns zero. A read through the primary address still returns the stored shared bit.
- R6: The control register at base + 0x04 holds the open bit at bit 0 and the guard bit at bit 2. Both are software read-write, both drive hardware outputs, and all other read bits are zero.
- R7: Read data is zero whenever the read strobe is low or the address matches no register.
- R8: A write to an address that matches no register changes no field.
- R9: Read data shows the stored value before the edge. A read in the same cycle as a write to that address returns the old value, and the next read returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, combinational |
| ext_wr_lock | input | 1 | External write lock for the alias address |
| hw_shared | output | 1 | Shared bit value |
| hw_rd_open | output | 1 | Control open bit (alias readable when 1) |
| hw_wr_guard | output | 1 | Control guard bit (alias write-locked when 1) |

## Verification
The shared bit is written through both addresses and read back through the other one. This separates a single shared flip-flop from two independent copies.

Alias writes are tried under each write-lock source on its own:
- the guard bit only;
- the external input only;
- neither source.

Each source must be able to block the write, and the primary path must stay open throughout.

Reads are made through the alias with the open bit set and with it cleared, and at unmapped addresses. Same-cycle read/write and a reset mid-run cover timing and priority.

// File: rtl/cfg_alias_pkg.sv
package cfg_alias_pkg;

    // bit positions decoded by the control register users
    localparam int OPEN_BIT  = 0;
    localparam int GUARD_BIT = 2;
    localparam int SHARED_BIT = 0;

    typedef struct packed {
        logic shared;
        logic rd_open;
        logic wr_guard;
    } cfg_state_t;

    localparam cfg_state_t CFG_RESET = '{shared: 1'b1, rd_open: 1'b1, wr_guard: 1'b1};

    typedef struct packed {
        logic alias_hit;
        logic ctrl_hit;
        logic main_hit;
    } cfg_sel_t;

endpackage

// File: rtl/cfg_alias_decode.sv
module cfg_alias_decode
    import cfg_alias_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] BASE_ADDR = 32'h0,
    parameter logic [31:0] ALIAS_OFF = 32'h0,
    parameter logic [31:0] CTRL_OFF  = 32'h4,
    parameter logic [31:0] MAIN_OFF  = 32'h8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output cfg_sel_t          wr_sel,
    output cfg_sel_t          rd_sel
);
    localparam logic [31:0] ALIAS_FULL = BASE_ADDR + ALIAS_OFF;
    localparam logic [31:0] CTRL_FULL  = BASE_ADDR + CTRL_OFF;
    localparam logic [31:0] MAIN_FULL  = BASE_ADDR + MAIN_OFF;
    localparam logic [ADDR_W-1:0] ALIAS_A = ALIAS_FULL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] CTRL_A  = CTRL_FULL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] MAIN_A  = MAIN_FULL[ADDR_W-1:0];

    cfg_sel_t hit;

    always_comb begin
        hit.alias_hit = (addr == ALIAS_A);
        hit.ctrl_hit  = (addr == CTRL_A);
        hit.main_hit  = (addr == MAIN_A);
    end

    always_comb begin
        wr_sel = hit & {3{wr_stb}};
        rd_sel = hit & {3{rd_stb}};
    end
endmodule

// File: rtl/cfg_alias_lock.sv
module cfg_alias_lock
    import cfg_alias_pkg::*;
#(
    parameter bit EXT_LOCK_EN = 1'b1
) (
    input  cfg_state_t st_q,
    input  logic       ext_wr_lock,
    output logic       wr_lock,
    output logic       rd_lock
);
    logic ext_term;

    generate
        if (EXT_LOCK_EN) begin : g_ext
            assign ext_term = ext_wr_lock;
        end else begin : g_no_ext
            logic unused_ext;
            assign unused_ext = ext_wr_lock;
            assign ext_term   = 1'b0;
        end
    endgenerate

    always_comb begin
        wr_lock = st_q.wr_guard | ext_term;
        rd_lock = ~st_q.rd_open;
    end
endmodule

// File: rtl/cfg_alias_store.sv
module cfg_alias_store
    import cfg_alias_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_sel_t          wr_sel,
    input  logic              wr_lock,
    input  logic [DATA_W-1:0] wdata,
    output cfg_state_t        st_q
);
    cfg_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (wr_sel.main_hit) begin
            st_d.shared = wdata[SHARED_BIT];
        end else if (wr_sel.alias_hit && !wr_lock) begin
            st_d.shared = wdata[SHARED_BIT];
        end
        if (wr_sel.ctrl_hit) begin
            st_d.rd_open  = wdata[OPEN_BIT];
            st_d.wr_guard = wdata[GUARD_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CFG_RESET;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cfg_alias_rdmux.sv
module cfg_alias_rdmux
    import cfg_alias_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  cfg_sel_t          rd_sel,
    input  cfg_state_t        st_q,
    input  logic              rd_lock,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_sel.main_hit) begin
            rdata[SHARED_BIT] = st_q.shared;
        end
        if (rd_sel.alias_hit) begin
            rdata[SHARED_BIT] = st_q.shared & ~rd_lock;
        end
        if (rd_sel.ctrl_hit) begin
            rdata[OPEN_BIT]  = st_q.rd_open;
            rdata[GUARD_BIT] = st_q.wr_guard;
        end
    end
endmodule

// File: rtl/cfg_alias_bank.sv
module cfg_alias_bank
    import cfg_alias_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter logic [31:0] BASE_ADDR   = 32'h0,
    parameter logic [31:0] ALIAS_OFF   = 32'h0,
    parameter logic [31:0] CTRL_OFF    = 32'h4,
    parameter logic [31:0] MAIN_OFF    = 32'h8,
    parameter bit          EXT_LOCK_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_wr_lock,
    output logic              hw_shared,
    output logic              hw_rd_open,
    output logic              hw_wr_guard
);
    cfg_sel_t   wr_sel;
    cfg_sel_t   rd_sel;
    cfg_state_t st_q;
    logic       wr_lock;
    logic       rd_lock;

    cfg_alias_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
        .ALIAS_OFF(ALIAS_OFF), .CTRL_OFF(CTRL_OFF), .MAIN_OFF(MAIN_OFF)
    ) u_decode (
        .addr(bus_addr), .wr_stb(bus_wr), .rd_stb(bus_rd),
        .wr_sel(wr_sel), .rd_sel(rd_sel)
    );

    cfg_alias_lock #(.EXT_LOCK_EN(EXT_LOCK_EN)) u_lock (
        .st_q(st_q), .ext_wr_lock(ext_wr_lock),
        .wr_lock(wr_lock), .rd_lock(rd_lock)
    );

    cfg_alias_store #(.DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_lock(wr_lock),
        .wdata(bus_wdata), .st_q(st_q)
    );

    cfg_alias_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .rd_sel(rd_sel), .st_q(st_q), .rd_lock(rd_lock), .rdata(bus_rdata)
    );

    assign hw_shared   = st_q.shared;
    assign hw_rd_open  = st_q.rd_open;
    assign hw_wr_guard = st_q.wr_guard;
endmodule

// File: rtl/cfg_alias_bank_chk.sv
module cfg_alias_bank_chk #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0,
    parameter logic [31:0] ALIAS_OFF = 32'h0,
    parameter logic [31:0] CTRL_OFF  = 32'h4,
    parameter logic [31:0] MAIN_OFF  = 32'h8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ext_wr_lock,
    input logic              hw_shared,
    input logic              hw_rd_open,
    input logic              hw_wr_guard
);
    localparam logic [31:0] A_FULL = BASE_ADDR + ALIAS_OFF;
    localparam logic [31:0] C_FULL = BASE_ADDR + CTRL_OFF;
    localparam logic [31:0] M_FULL = BASE_ADDR + MAIN_OFF;
    localparam logic [ADDR_W-1:0] A_ADDR = A_FULL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] C_ADDR = C_FULL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] M_ADDR = M_FULL[ADDR_W-1:0];

    logic unmapped;
    logic was_in_rst_q;
    logic unused_chk;

    assign unmapped   = (bus_addr != A_ADDR) && (bus_addr != C_ADDR) && (bus_addr != M_ADDR);
    assign unused_chk = ^bus_wdata;

    always_ff @(posedge clk) was_in_rst_q <= !rst_n;

    // R1: after a reset edge every field is back at 1
    always @(negedge clk) begin
        if (was_in_rst_q === 1'b1) begin
            a_reset_r1: assert ({hw_shared, hw_rd_open, hw_wr_guard} == 3'b111)
                else $error("reset values wrong");
        end
    end

    p_main_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == M_ADDR) |=> (hw_shared == $past(bus_wdata[0])));

    p_alias_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ADDR && (hw_wr_guard || ext_wr_lock)) |=> $stable(hw_shared));

    p_alias_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ADDR && !hw_wr_guard && !ext_wr_lock)
        |=> (hw_shared == $past(bus_wdata[0])));

    p_alias_rdlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ADDR && !hw_rd_open) |-> (bus_rdata == '0));

    p_ctrl_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == C_ADDR) |-> (bus_rdata[0] == hw_rd_open && bus_rdata[2] == hw_wr_guard
                                            && $countones(bus_rdata) <= 2 && bus_rdata[1] == 1'b0));

    p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || unmapped) |-> (bus_rdata == '0));

    p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && unmapped) |=> ($stable(hw_shared) && $stable(hw_rd_open) && $stable(hw_wr_guard)));
endmodule

bind cfg_alias_bank cfg_alias_bank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
    .ALIAS_OFF(ALIAS_OFF), .CTRL_OFF(CTRL_OFF), .MAIN_OFF(MAIN_OFF)
) u_chk (.*);

// File: tb/test_cfg_alias_bank.sv
module test_cfg_alias_bank;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 21;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic        lock;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic [2:0]  exp_hw;   // {shared, rd_open, wr_guard}
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{1'b0,1'b1,1'b0,8'h08,32'h0,32'h1,3'b111,4'd2},        // R2 read primary after reset
        '{1'b0,1'b1,1'b0,8'h00,32'h0,32'h1,3'b111,4'd5},        // R5 alias open
        '{1'b0,1'b1,1'b0,8'h04,32'h0,32'h5,3'b111,4'd6},        // R6 control reset value
        '{1'b1,1'b0,1'b0,8'h00,32'h0,32'h0,3'b111,4'd4},        // R4 guard blocks alias write
        '{1'b1,1'b0,1'b0,8'h04,32'hFFFFFFFF,32'h0,3'b111,4'd6}, // R6 all ones
        '{1'b1,1'b0,1'b0,8'h04,32'h1,32'h0,3'b110,4'd6},        // R6 clear guard
        '{1'b0,1'b1,1'b0,8'h04,32'h0,32'h1,3'b110,4'd6},        // R6 read back
        '{1'b1,1'b0,1'b0,8'h00,32'h0,32'h0,3'b010,4'd3},        // R3 alias write open
        '{1'b0,1'b1,1'b0,8'h08,32'h0,32'h0,3'b010,4'd3},        // R3 seen at primary
        '{1'b1,1'b0,1'b1,8'h00,32'h1,32'h0,3'b010,4'd4},        // R4 external lock blocks
        '{1'b1,1'b0,1'b1,8'h08,32'h1,32'h0,3'b110,4'd4},        // R4 primary still writes
        '{1'b0,1'b1,1'b0,8'h00,32'h0,32'h1,3'b110,4'd3},        // R3 seen at alias
        '{1'b1,1'b0,1'b0,8'h04,32'h0,32'h0,3'b100,4'd6},        // R6 clear open
        '{1'b0,1'b1,1'b0,8'h00,32'h0,32'h0,3'b100,4'd5},        // R5 alias read locked
        '{1'b0,1'b1,1'b0,8'h08,32'h0,32'h1,3'b100,4'd5},        // R5 primary still reads
        '{1'b1,1'b0,1'b0,8'h10,32'h0,32'h0,3'b100,4'd8},        // R8 unmapped write
        '{1'b0,1'b1,1'b0,8'h10,32'h0,32'h0,3'b100,4'd7},        // R7 unmapped read
        '{1'b1,1'b0,1'b0,8'h0C,32'h0,32'h0,3'b100,4'd8},        // R8 gap write
        '{1'b1,1'b0,1'b0,8'h08,32'hFFFFFFFE,32'h0,3'b000,4'd2}, // R2 only bit 0 matters
        '{1'b0,1'b1,1'b0,8'h08,32'h0,32'h0,3'b000,4'd2},        // R2 read zero
        '{1'b1,1'b0,1'b0,8'h00,32'h1,32'h0,3'b100,4'd3}         // R3 alias writes 1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        ext_wr_lock = 1'b0;
    logic        hw_shared, hw_rd_open, hw_wr_guard;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_alias_bank i_cfg_alias_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ext_wr_lock(ext_wr_lock), .hw_shared(hw_shared),
        .hw_rd_open(hw_rd_open), .hw_wr_guard(hw_wr_guard)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_hw(input string req, input logic [2:0] exp);
        check32(req, {29'd0, hw_shared, hw_rd_open, hw_wr_guard}, {29'd0, exp});
    endtask

    task automatic run_vec(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        bus_addr = v.addr; bus_wdata = v.wdata;
        bus_wr = v.wr; bus_rd = v.rd; ext_wr_lock = v.lock;
        #1;
        if (v.rd) check32(tag, bus_rdata, v.exp_rd);
        @(posedge clk);
        #(CLK_PERIOD/4);
        bus_wr = 1'b0; bus_rd = 1'b0; ext_wr_lock = 1'b0;
        check_hw(tag, v.exp_hw);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check_hw("R1", 3'b111);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < N_VEC; i++) run_vec(VECS[i]);

        // R9: same-cycle read sees old value, next read sees new
        @(negedge clk);
        bus_addr = 8'h08; bus_wdata = 32'h0; bus_wr = 1'b1; bus_rd = 1'b1;
        #1 check32("R9", bus_rdata, 32'h1);
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check32("R9", bus_rdata, 32'h0);

        // R7: strobe low, mapped address
        bus_rd = 1'b0; bus_addr = 8'h04;
        #1 check32("R7", bus_rdata, 32'h0);

        // R1: reset wins over a simultaneous write
        @(negedge clk);
        rst_n = 1'b0; bus_addr = 8'h04; bus_wdata = 32'h0; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check_hw("R1", 3'b111);
        rst_n = 1'b1;
        bus_addr = 8'h04; bus_rd = 1'b1;
        #1 check32("R1", bus_rdata, 32'h5);
        bus_rd = 1'b0;

        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule